// File: doc/BRIEF.md
# Circular Descriptor List Engine

This block is the device side of a ring-based request exchange. A host fills units of an inbound ring, each carrying the address and byte size of a request packet. It then moves a write pointer to the index of the last unit it filled. The engine hands the new units to a local consumer one at a time, in ring order. When the consumer finishes a request, it reports a flag word. The engine stores that word, with two marker bits set, in the next outbound unit, publishes that unit's index in a copy-pointer shadow, and flags an interrupt cause. The host keeps its own read index N. When the shadow differs from N, the host reads unit N+1.

Ring storage is kept in small internal arrays that the host reaches through address windows. The block also holds readable 64-bit base-address registers for the two rings and the shadow. A side channel carries single non-queued commands from host to local side, with a reply register and a set of sticky doorbell bits. Host access is one cycle per write; read data is combinational from the address.

Register words (byte offsets, region `host_addr[11:10]` = 00):

| Offset | Register |
|---|---|
| 0x00/0x04 | inbound base low/high |
| 0x08/0x0C | outbound base low/high |
| 0x10/0x14 | shadow base low/high |
| 0x20 | config: bits [7:0] = ring count |
| 0x24 | inbound write pointer |
| 0x28 | copy-pointer shadow (read only) |
| 0x30 | cause (W1C) |
| 0x34 | cause enable |
| 0x40 | host-to-local message |
| 0x44 | local reply (read only) |
| 0x48 | doorbell (W1C) |
| 0x4C | doorbell enable |

The ring windows are:
- Inbound unit k: request address at `0x400 + 8k`, size at `0x404 + 8k`.
- Outbound unit k: `0x800 + 4k`.

Top module: `ring_desc_engine`

## Requirements
- R1: After reset, `cons_valid`, `irq_out` and `db_irq` are 0, and the write pointer, shadow, cause and doorbell registers read 0.
- R2: While the engine's read index differs from the write pointer, `cons_valid` is 1. `cons_idx` is then the read index plus one (wrapped), and `cons_addr`/`cons_size` are that unit's contents, with `cons_addr[4:0]` forced to 0 (32-byte alignment). Each cycle with `cons_ready` high advances the read index by one; when the indices match, `cons_valid` is 0.
- R3: Indices wrap to 0 after the ring count from config bits [7:0]. A count of 0 or above 64 acts as 64.
- R4: One cycle after `cpl_valid`, the outbound unit after the previous shadow (wrapped) holds `cpl_flag | 0xC0000000`, and the shadow reads that unit's index.
- R5: Cause bit 0 is set by a completion, and bit 1 by `loc_msg_valid`. Writing 1 to a bit clears it; a set in the same cycle wins.
- R6: `irq_out` is 1 exactly when some cause bit and its enable bit (bits [1:0]) are both 1.
- R7: A host write to the message register drives its value on `msg_to_local` and pulses `msg_strobe` for one cycle. `loc_msg_valid` loads `loc_msg_data` into the reply register.
- R8: Doorbell bits are set by `loc_db_set` and cleared by writing 1. `db_irq` is 1 when any doorbell bit and its enable bit are both 1.
- R9: A write to config returns the read index, write pointer and shadow to 0.
- R10: While `cons_valid` is 1 and `cons_ready` is 0, `cons_valid`, `cons_idx` and `cons_addr` hold.
- R11: The six base-address words read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_wr | input | 1 | host write strobe |
| host_addr | input | 12 | host byte address |
| host_wdata | input | 32 | host write data |
| host_rdata | output | 32 | host read data for host_addr |
| cons_valid | output | 1 | an inbound unit is offered |
| cons_ready | input | 1 | consumer takes the offered unit |
| cons_idx | output | 6 | index of the offered unit |
| cons_addr | output | 32 | aligned request address |
| cons_size | output | 32 | request size |
| cpl_valid | input | 1 | completion strobe |
| cpl_flag | input | 32 | completed request's flag word |
| msg_to_local | output | 32 | last host message |
| msg_strobe | output | 1 | one-cycle pulse on new message |
| loc_msg_valid | input | 1 | local reply strobe |
| loc_msg_data | input | 32 | local reply value |
| loc_db_set | input | 8 | doorbell set bits |
| irq_out | output | 1 | enabled cause pending |
| db_irq | output | 1 | enabled doorbell pending |

## Verification
The assertions assume a host that never moves the write pointer to an index at or beyond the ring count. They also assume the consumer does not raise `cons_ready` while `cons_valid` is low. The stimulus respects both conditions:
- Every pointer value it writes is below the count just configured.
- It raises ready only for a single cycle, after first observing a valid unit.

Completions are sent only after a config write has set the outbound position, so no outbound unit is overwritten before it is read back.

// File: rtl/rde_pkg.sv
package rde_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ALIGN_LSB = 5;
  localparam logic [31:0] HOST_MARK = 32'hC000_0000;

  localparam logic [7:0] OFS_IN_BASE_LO  = 8'h00;
  localparam logic [7:0] OFS_IN_BASE_HI  = 8'h04;
  localparam logic [7:0] OFS_OUT_BASE_LO = 8'h08;
  localparam logic [7:0] OFS_OUT_BASE_HI = 8'h0C;
  localparam logic [7:0] OFS_SHD_BASE_LO = 8'h10;
  localparam logic [7:0] OFS_SHD_BASE_HI = 8'h14;
  localparam logic [7:0] OFS_CFG         = 8'h20;
  localparam logic [7:0] OFS_WPTR        = 8'h24;
  localparam logic [7:0] OFS_SHADOW      = 8'h28;
  localparam logic [7:0] OFS_CAUSE       = 8'h30;
  localparam logic [7:0] OFS_ENABLE      = 8'h34;
  localparam logic [7:0] OFS_MSG         = 8'h40;
  localparam logic [7:0] OFS_REPLY       = 8'h44;
  localparam logic [7:0] OFS_DB          = 8'h48;
  localparam logic [7:0] OFS_DB_EN       = 8'h4C;

  localparam int unsigned NUM_BASE  = 6;
  localparam int unsigned CAUSE_W   = 2;
  localparam int unsigned CAUSE_CPL = 0;
  localparam int unsigned CAUSE_MSG = 1;
endpackage

// File: rtl/rde_inbound.sv
module rde_inbound
  import rde_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [IDX_W:0]    cnt,
  input  logic              wptr_we,
  input  logic [IDX_W-1:0]  wptr_in,
  output logic [IDX_W-1:0]  wptr_q,
  input  logic              unit_we,
  input  logic [IDX_W-1:0]  unit_idx,
  input  logic              unit_hi,
  input  logic [WORD_W-1:0] unit_wdata,
  output logic [WORD_W-1:0] unit_rdata,
  output logic              cons_valid,
  input  logic              cons_ready,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [WORD_W-1:0] cons_addr,
  output logic [WORD_W-1:0] cons_size
);

  logic [WORD_W-1:0] addr_mem [DEPTH];
  logic [WORD_W-1:0] size_mem [DEPTH];
  logic [IDX_W-1:0]  rd_q, rd_d, wptr_d;

  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] i,
                                                 input logic [IDX_W:0]   n);
    logic [IDX_W:0] inc;
    inc = {1'b0, i} + {{IDX_W{1'b0}}, 1'b1};
    return (inc >= n) ? '0 : inc[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (unit_we && !unit_hi) addr_mem[unit_idx] <= unit_wdata;
    if (unit_we &&  unit_hi) size_mem[unit_idx] <= unit_wdata;
  end

  assign unit_rdata = unit_hi ? size_mem[unit_idx] : addr_mem[unit_idx];

  assign cons_valid = (rd_q != wptr_q);
  assign cons_idx   = ring_step(rd_q, cnt);
  assign cons_addr  = {addr_mem[cons_idx][WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign cons_size  = size_mem[cons_idx];

  always_comb begin
    rd_d   = rd_q;
    wptr_d = wptr_q;
    if (clr) begin
      rd_d   = '0;
      wptr_d = '0;
    end else begin
      if (cons_valid && cons_ready) rd_d = cons_idx;
      if (wptr_we) wptr_d = wptr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      wptr_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wptr_q <= wptr_d;
    end
  end

  AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && !cons_ready && !clr && !wptr_we && !unit_we)
      |=> (cons_valid && $stable(cons_idx) && $stable(cons_addr))); // R10

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |-> ({1'b0, cons_idx} < cnt)); // R3

endmodule

// File: rtl/rde_outbound.sv
module rde_outbound
  import rde_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [IDX_W:0]     cnt,
  input  logic               cpl_valid,
  input  logic [WORD_W-1:0]  cpl_flag,
  input  logic               msg_done,
  input  logic [CAUSE_W-1:0] cause_clr,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WORD_W-1:0]  rd_data,
  output logic [IDX_W-1:0]   shadow_q,
  output logic [CAUSE_W-1:0] cause_q
);

  logic [WORD_W-1:0]  out_mem [DEPTH];
  logic [IDX_W-1:0]   shadow_d, slot;
  logic [CAUSE_W-1:0] cause_d, cause_set;

  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] i,
                                                 input logic [IDX_W:0]   n);
    logic [IDX_W:0] inc;
    inc = {1'b0, i} + {{IDX_W{1'b0}}, 1'b1};
    return (inc >= n) ? '0 : inc[IDX_W-1:0];
  endfunction

  assign slot = ring_step(shadow_q, cnt);

  always_ff @(posedge clk) begin
    if (cpl_valid) out_mem[slot] <= cpl_flag | HOST_MARK;
  end

  assign rd_data = out_mem[rd_idx];

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_CPL] = cpl_valid;
    cause_set[CAUSE_MSG] = msg_done;
    cause_d  = (cause_q & ~cause_clr) | cause_set;
    shadow_d = shadow_q;
    if (clr)            shadow_d = '0;
    else if (cpl_valid) shadow_d = slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      cause_q  <= '0;
    end else begin
      shadow_q <= shadow_d;
      cause_q  <= cause_d;
    end
  end

  AST_CPL_RAISES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> cause_q[CAUSE_CPL]); // R5

  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_valid && !clr) |=> $stable(shadow_q)); // R4

endmodule

// File: rtl/rde_msg.sv
module rde_msg
  import rde_pkg::*;
#(
  parameter int unsigned DB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_we,
  input  logic [WORD_W-1:0] msg_wdata,
  output logic [WORD_W-1:0] msg_q,
  output logic              msg_strobe,
  input  logic              reply_valid,
  input  logic [WORD_W-1:0] reply_data,
  output logic [WORD_W-1:0] reply_q,
  input  logic [DB_W-1:0]   db_set,
  input  logic [DB_W-1:0]   db_clr,
  input  logic              db_en_we,
  input  logic [DB_W-1:0]   db_en_wdata,
  output logic [DB_W-1:0]   db_q,
  output logic [DB_W-1:0]   db_en_q,
  output logic              db_irq
);

  logic [WORD_W-1:0] msg_d, reply_d;
  logic [DB_W-1:0]   db_d, db_en_d;

  always_comb begin
    msg_d   = msg_we      ? msg_wdata   : msg_q;
    reply_d = reply_valid ? reply_data  : reply_q;
    db_en_d = db_en_we    ? db_en_wdata : db_en_q;
    db_d    = (db_q & ~db_clr) | db_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q      <= '0;
      msg_strobe <= 1'b0;
      reply_q    <= '0;
      db_q       <= '0;
      db_en_q    <= '0;
    end else begin
      msg_q      <= msg_d;
      msg_strobe <= msg_we;
      reply_q    <= reply_d;
      db_q       <= db_d;
      db_en_q    <= db_en_d;
    end
  end

  assign db_irq = |(db_q & db_en_q);

  AST_DB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (db_clr == '0) |=> ((db_q & $past(db_q)) == $past(db_q))); // R8

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_strobe && !msg_we) |=> !msg_strobe); // R7

endmodule

// File: rtl/ring_desc_engine.sv
module ring_desc_engine
  import rde_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DB_W   = 8,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              cons_valid,
  input  logic              cons_ready,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [31:0]       cons_addr,
  output logic [31:0]       cons_size,
  input  logic              cpl_valid,
  input  logic [31:0]       cpl_flag,
  output logic [31:0]       msg_to_local,
  output logic              msg_strobe,
  input  logic              loc_msg_valid,
  input  logic [31:0]       loc_msg_data,
  input  logic [DB_W-1:0]   loc_db_set,
  output logic              irq_out,
  output logic              db_irq
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // address decode
  logic       lsb_ok, reg_hit, in_hit, out_hit;
  logic [7:0] ofs;
  assign lsb_ok  = (host_addr[1:0] == 2'b00);
  assign ofs     = host_addr[7:0];
  assign reg_hit = lsb_ok && (host_addr[ADDR_W-1:8] == '0);
  assign in_hit  = lsb_ok && (host_addr[ADDR_W-1:ADDR_W-2] == 2'b01) &&
                   ((host_addr[ADDR_W-3:0] >> (IDX_W + 3)) == '0);
  assign out_hit = lsb_ok && (host_addr[ADDR_W-1:ADDR_W-2] == 2'b10) &&
                   ((host_addr[ADDR_W-3:0] >> (IDX_W + 2)) == '0);

  logic wr_cfg, wr_wptr, wr_cause, wr_en, wr_msg, wr_db, wr_db_en;
  assign wr_cfg   = host_wr && reg_hit && (ofs == OFS_CFG);
  assign wr_wptr  = host_wr && reg_hit && (ofs == OFS_WPTR);
  assign wr_cause = host_wr && reg_hit && (ofs == OFS_CAUSE);
  assign wr_en    = host_wr && reg_hit && (ofs == OFS_ENABLE);
  assign wr_msg   = host_wr && reg_hit && (ofs == OFS_MSG);
  assign wr_db    = host_wr && reg_hit && (ofs == OFS_DB);
  assign wr_db_en = host_wr && reg_hit && (ofs == OFS_DB_EN);

  // base-address words, one register each
  logic [31:0] base_q [NUM_BASE];
  logic [31:0] base_rd;
  logic        base_hit;
  assign base_hit = reg_hit && (ofs[7:5] == 3'b000) && (ofs[4:2] < 3'(NUM_BASE));
  assign base_rd  = base_hit ? base_q[ofs[4:2]] : '0;

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic        we;
    logic [31:0] d;
    assign we = host_wr && base_hit && (ofs[4:2] == 3'(g));
    assign d  = we ? host_wdata : base_q[g];
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) base_q[g] <= '0;
      else        base_q[g] <= d;
    end
  end

  // configuration and cause enable
  logic [7:0]         cfg_q, cfg_d;
  logic [CAUSE_W-1:0] en_q, en_d;
  logic [CNT_W-1:0]   cnt_eff;
  always_comb begin
    cfg_d = wr_cfg ? host_wdata[7:0]         : cfg_q;
    en_d  = wr_en  ? host_wdata[CAUSE_W-1:0] : en_q;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q <= '0;
      en_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      en_q  <= en_d;
    end
  end
  assign cnt_eff = ((cfg_q == 8'd0) || (cfg_q > 8'(DEPTH))) ? CNT_W'(DEPTH)
                                                            : cfg_q[CNT_W-1:0];

  // sub-blocks
  logic [IDX_W-1:0]   wptr_q, shadow_q;
  logic [31:0]        in_rdata, out_rdata, reply_q;
  logic [CAUSE_W-1:0] cause_q, cause_clr;
  logic [DB_W-1:0]    db_q, db_en_q, db_clr;

  assign cause_clr = wr_cause ? host_wdata[CAUSE_W-1:0] : '0;
  assign db_clr    = wr_db    ? host_wdata[DB_W-1:0]    : '0;

  rde_inbound #(.DEPTH(DEPTH)) u_inbound (
    .clk        (clk),
    .rst_n      (rst_i),
    .clr        (wr_cfg),
    .cnt        (cnt_eff),
    .wptr_we    (wr_wptr),
    .wptr_in    (host_wdata[IDX_W-1:0]),
    .wptr_q     (wptr_q),
    .unit_we    (host_wr && in_hit),
    .unit_idx   (host_addr[IDX_W+2:3]),
    .unit_hi    (host_addr[2]),
    .unit_wdata (host_wdata),
    .unit_rdata (in_rdata),
    .cons_valid (cons_valid),
    .cons_ready (cons_ready),
    .cons_idx   (cons_idx),
    .cons_addr  (cons_addr),
    .cons_size  (cons_size)
  );

  rde_outbound #(.DEPTH(DEPTH)) u_outbound (
    .clk       (clk),
    .rst_n     (rst_i),
    .clr       (wr_cfg),
    .cnt       (cnt_eff),
    .cpl_valid (cpl_valid),
    .cpl_flag  (cpl_flag),
    .msg_done  (loc_msg_valid),
    .cause_clr (cause_clr),
    .rd_idx    (host_addr[IDX_W+1:2]),
    .rd_data   (out_rdata),
    .shadow_q  (shadow_q),
    .cause_q   (cause_q)
  );

  rde_msg #(.DB_W(DB_W)) u_msg (
    .clk         (clk),
    .rst_n       (rst_i),
    .msg_we      (wr_msg),
    .msg_wdata   (host_wdata),
    .msg_q       (msg_to_local),
    .msg_strobe  (msg_strobe),
    .reply_valid (loc_msg_valid),
    .reply_data  (loc_msg_data),
    .reply_q     (reply_q),
    .db_set      (loc_db_set),
    .db_clr      (db_clr),
    .db_en_we    (wr_db_en),
    .db_en_wdata (host_wdata[DB_W-1:0]),
    .db_q        (db_q),
    .db_en_q     (db_en_q),
    .db_irq      (db_irq)
  );

  assign irq_out = |(cause_q & en_q);

  // read mux
  always_comb begin
    host_rdata = '0;
    if (in_hit)       host_rdata = in_rdata;
    else if (out_hit) host_rdata = out_rdata;
    else if (reg_hit) begin
      case (ofs)
        OFS_CFG:    host_rdata = {24'd0, cfg_q};
        OFS_WPTR:   host_rdata = 32'(wptr_q);
        OFS_SHADOW: host_rdata = 32'(shadow_q);
        OFS_CAUSE:  host_rdata = 32'(cause_q);
        OFS_ENABLE: host_rdata = 32'(en_q);
        OFS_MSG:    host_rdata = msg_to_local;
        OFS_REPLY:  host_rdata = reply_q;
        OFS_DB:     host_rdata = 32'(db_q);
        OFS_DB_EN:  host_rdata = 32'(db_en_q);
        default:    host_rdata = base_rd;
      endcase
    end
  end

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    wr_cfg |=> (!cons_valid && (shadow_q == '0))); // R9

endmodule

// File: tb/ring_desc_engine_bench.sv
module ring_desc_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        cons_valid, cons_ready;
  logic [5:0]  cons_idx;
  logic [31:0] cons_addr, cons_size;
  logic        cpl_valid;
  logic [31:0] cpl_flag, msg_to_local;
  logic        msg_strobe, loc_msg_valid;
  logic [31:0] loc_msg_data;
  logic [7:0]  loc_db_set;
  logic        irq_out, db_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_desc_engine u_ring_desc_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_idx(cons_idx),
    .cons_addr(cons_addr), .cons_size(cons_size),
    .cpl_valid(cpl_valid), .cpl_flag(cpl_flag),
    .msg_to_local(msg_to_local), .msg_strobe(msg_strobe),
    .loc_msg_valid(loc_msg_valid), .loc_msg_data(loc_msg_data),
    .loc_db_set(loc_db_set), .irq_out(irq_out), .db_irq(db_irq)
  );

  // flag in, expected outbound word, expected shadow (ring count 5)
  localparam logic [95:0] CPL_VEC [6] = '{
    {32'h0000_0001, 32'hC000_0001, 32'd1},
    {32'h0000_0022, 32'hC000_0022, 32'd2},
    {32'h1234_5678, 32'hD234_5678, 32'd3},
    {32'h8000_0003, 32'hC000_0003, 32'd4},
    {32'h4000_0000, 32'hC000_0000, 32'd0},
    {32'h0000_ABCD, 32'hC000_ABCD, 32'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic fill(input int k, input logic [31:0] a, input logic [31:0] s);
    hwrite(12'h400 + 12'(8*k), a);
    hwrite(12'h404 + 12'(8*k), s);
  endtask

  task automatic take(input string req, input int exp_idx);
    chk({req, " valid"}, 32'(cons_valid), 32'd1);
    chk({req, " idx"}, 32'(cons_idx), 32'(exp_idx));
    cons_ready = 1'b1;
    @(negedge clk);
    cons_ready = 1'b0;
  endtask

  task automatic complete(input logic [31:0] f);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_flag = f;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    cons_ready = 1'b0; cpl_valid = 1'b0; cpl_flag = '0;
    loc_msg_valid = 1'b0; loc_msg_data = '0; loc_db_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cons_valid", 32'(cons_valid), 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 db_irq", 32'(db_irq), 0);
    hread(12'h024, rd); chk("R1 wptr", rd, 0);
    hread(12'h028, rd); chk("R1 shadow", rd, 0);
    hread(12'h030, rd); chk("R1 cause", rd, 0);
    hread(12'h048, rd); chk("R1 doorbell", rd, 0);

    // R11 base words
    for (int i = 0; i < 6; i++) hwrite(12'(4*i), 32'hB000_0000 + 32'(i*17));
    for (int i = 0; i < 6; i++) begin
      hread(12'(4*i), rd); chk("R11 base readback", rd, 32'hB000_0000 + 32'(i*17));
    end

    // R2 in-order consumption with alignment
    hwrite(12'h020, 32'd8);
    for (int k = 1; k <= 3; k++) fill(k, 32'h1000_0000 + 32'(k*64) + 32'h07, 32'(k*256));
    hwrite(12'h024, 32'd3);
    for (int k = 1; k <= 3; k++) begin
      chk("R2 addr aligned", cons_addr, 32'h1000_0000 + 32'(k*64));
      chk("R2 size", cons_size, 32'(k*256));
      take("R2", k);
    end
    chk("R2 empty", 32'(cons_valid), 0);

    // R10 offer holds without ready
    fill(4, 32'h2000_001F, 32'h40);
    hwrite(12'h024, 32'd4);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R10 hold valid", 32'(cons_valid), 1);
      chk("R10 hold idx", 32'(cons_idx), 4);
      chk("R10 hold addr", cons_addr, 32'h2000_0000);
    end
    take("R10", 4);

    // R9 config write clears indices
    hwrite(12'h020, 32'd5);
    hread(12'h024, rd); chk("R9 wptr cleared", rd, 0);
    chk("R9 no offer", 32'(cons_valid), 0);

    // R3 wrap at count 5
    for (int k = 0; k < 5; k++) fill(k, 32'(k*32), 32'(k + 1));
    hwrite(12'h024, 32'd4);
    for (int k = 1; k <= 4; k++) take("R3 pre-wrap", k);
    hwrite(12'h024, 32'd1);
    take("R3 wrap", 0);
    take("R3 wrap", 1);
    chk("R3 empty after wrap", 32'(cons_valid), 0);

    // R3 count above 64 acts as 64
    hwrite(12'h020, 32'd200);
    hwrite(12'h024, 32'd63);
    for (int k = 1; k <= 63; k++) begin
      if (k == 63) take("R3 large count", 63);
      else begin cons_ready = 1'b1; @(negedge clk); cons_ready = 1'b0; end
    end
    chk("R3 large count empty", 32'(cons_valid), 0);

    // R4/R5/R6 completion table
    hwrite(12'h020, 32'd5);
    hwrite(12'h034, 32'd1);
    for (int v = 0; v < 6; v++) begin
      complete(CPL_VEC[v][95:64]);
      hread(12'h028, rd); chk("R4 shadow", rd, CPL_VEC[v][31:0]);
      hread(12'h800 + 12'(4*CPL_VEC[v][31:0]), rd); chk("R4 outbound word", rd, CPL_VEC[v][63:32]);
      chk("R6 irq on", 32'(irq_out), 1);
      hwrite(12'h030, 32'd1);
      chk("R5 w1c", 32'(irq_out), 0);
    end

    // R5 set wins over clear
    @(negedge clk);
    host_wr = 1'b1; host_addr = 12'h030; host_wdata = 32'd1;
    cpl_valid = 1'b1; cpl_flag = 32'h5;
    @(negedge clk);
    host_wr = 1'b0; cpl_valid = 1'b0;
    hread(12'h030, rd); chk("R5 set wins", rd, 1);

    // R6 masked
    hwrite(12'h034, 32'd0);
    chk("R6 masked", 32'(irq_out), 0);
    hwrite(12'h030, 32'd3);

    // R7 message exchange
    @(negedge clk);
    host_wr = 1'b1; host_addr = 12'h040; host_wdata = 32'hA5A5_0001;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R7 strobe", 32'(msg_strobe), 1);
    chk("R7 message", msg_to_local, 32'hA5A5_0001);
    @(negedge clk);
    chk("R7 strobe single", 32'(msg_strobe), 0);
    loc_msg_valid = 1'b1; loc_msg_data = 32'hA5A5_0001;
    @(negedge clk);
    loc_msg_valid = 1'b0;
    hread(12'h044, rd); chk("R7 reply", rd, 32'hA5A5_0001);
    hread(12'h030, rd); chk("R5 msg cause", rd, 2);
    hwrite(12'h034, 32'd2);
    chk("R6 msg irq", 32'(irq_out), 1);

    // R8 doorbell
    @(negedge clk);
    loc_db_set = 8'h05;
    @(negedge clk);
    loc_db_set = 8'h00;
    hread(12'h048, rd); chk("R8 doorbell set", rd, 5);
    chk("R8 no enable", 32'(db_irq), 0);
    hwrite(12'h04C, 32'h04);
    chk("R8 enabled", 32'(db_irq), 1);
    hwrite(12'h048, 32'h04);
    hread(12'h048, rd); chk("R8 w1c", rd, 1);
    chk("R8 cleared irq", 32'(db_irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule